// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Trap States

This block is the control unit of a multicycle 32-bit load/store processor. Every instruction is split into a short series of clock cycles. In each cycle the sequencer reads the 6-bit opcode and the 6-bit function field from the instruction register, along with three ALU status bits: zero, overflow and bit 31 of the result. It then drives the datapath's multiplexer selects, register and memory write enables, and ALU function fields. The datapath registers, the memory and the ALU live outside the block.

Each instruction starts with a fetch cycle and a decode cycle. After that the path depends on the instruction class. ALU operations take an execute cycle and a write-back cycle. Loads take an address cycle, a memory read cycle and a register write cycle. Stores take an address cycle and a memory write cycle. All jumps and branches resolve in a single transfer cycle, where per-instruction select codes choose the next PC.

Two trap states handle abnormal cases. One is entered when an opcode/function pair is not supported. The other is entered when a signed add or subtract overflows. Each trap writes a cause code, stores the exception PC (the ALU computes PC−4) and loads the PC from a fixed handler vector. The current control phase is visible on an output, so the datapath and any observer can follow the sequence.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous active-high reset forces phase 0 (fetch). Phase codes are: 0 fetch, 1 decode, 2 address, 3 load read, 4 load write-back, 5 transfer, 6 store write, 7 execute, 8 ALU write-back, 9 overflow trap, 10 illegal trap. Fetch drives memory read=1, IR write=1, data-side address=0, ALU X=0 (PC), Y=0 (constant 4), add with class 2, PC write=1 and PC source=3. Fetch always goes to decode.
- R2: Decode drives ALU X=0 and Y=3 (4×imm), add with class 2. It asserts no PC, register or memory write and no memory read.
- R3: ALU-type instructions follow 0,1,7,8,0. Execute drives X=1, and Y=1 for opcode 0 (register form) or Y=2 for immediate forms. Write-back drives register write=1 and data source=1 (z), with destination 1 (rd) for opcode 0 and 0 (rt) otherwise.
- R4: ALU function fields in execute are as follows. The class code is 0 for lui (op 15), 1 for slt (fn 42) and slti (op 10), 2 for add (fn 32), sub (fn 34) and addi (op 8), and 3 for the logic ops. The logic code is 0 for and (fn 36) and andi (op 12), 1 for or (fn 37) and ori (op 13), 2 for xor (fn 38) and xori (op 14), and 3 for nor (fn 39). Subtract is 1 only for sub, slt and slti. Outside execute, the logic code is 0.
- R5: A load (op 35) follows 0,1,2,3,4,0. The address phase drives X=1, Y=2 and add with class 2. Load read drives data-side address=1 and memory read=1. Load write-back drives register write=1 with destination 0 and data source 0.
- R6: A store (op 43) follows 0,1,2,6,0. Store write drives data-side address=1 and memory write=1.
- R7: Jumps and branches follow 0,1,5,0. Transfer drives X=1, Y=1 and subtract with class 2. The vector select is 0 for j (op 2) and jal (op 3) and 1 for syscall (op 0, fn 12). The PC source is 0 for j, jal and syscall, 1 for jr (op 0, fn 8), and 2 for bltz (op 1), beq (op 4) and bne (op 5).
- R8: In transfer, PC write is 1 for j, jal, jr and syscall, equals the ALU zero flag for beq, equals its complement for bne, and equals ALU result bit 31 for bltz.
- R9: In transfer, jal additionally drives register write=1, destination 2 (r31) and data source 1. No other transfer instruction writes a register.
- R10: An overflow flag seen in execute for add, sub or addi sends the next phase to 9 instead of 8. For every other ALU instruction the flag is ignored and write-back follows as usual.
- R11: Both trap phases drive cause write=1 and EPC write=1, ALU X=0, Y=0 and subtract with class 2, vector select=1, PC source=0 and PC write=1. The cause value is 1 in phase 9 and 0 in phase 10. Both return to fetch.
- R12: Any opcode/function pair outside the 22 supported instructions goes from decode to phase 10. This includes opcode 0 with an unlisted function code.
- R13: Memory read and memory write are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 6 | Opcode field from the instruction register |
| fn_i | input | 6 | Function field from the instruction register |
| alu_zero_i | input | 1 | ALU result is zero |
| alu_ovf_i | input | 1 | ALU signed overflow |
| alu_msb_i | input | 1 | Bit 31 of the ALU result |
| phase_o | output | 4 | Current control phase code |
| pc_we_o | output | 1 | PC write enable |
| pc_src_o | output | 2 | PC source select |
| vec_sel_o | output | 1 | Jump address select: 0 jump target, 1 handler vector |
| mem_dside_o | output | 1 | Memory address from z register (1) instead of PC (0) |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ir_we_o | output | 1 | Instruction register write |
| rf_we_o | output | 1 | Register file write |
| rf_dst_o | output | 2 | Destination select: 0 rt, 1 rd, 2 r31 |
| rf_din_o | output | 1 | Register data source: 0 data register, 1 z register |
| alu_x_o | output | 1 | ALU X input: 0 PC, 1 x register |
| alu_y_o | output | 2 | ALU Y input: 0 constant 4, 1 y register, 2 imm, 3 4×imm |
| alu_sub_o | output | 1 | ALU subtract |
| alu_class_o | output | 2 | ALU function class |
| alu_logic_o | output | 2 | ALU logic function |
| cause_we_o | output | 1 | Cause register write |
| cause_o | output | 1 | Cause value: 1 overflow, 0 illegal |
| epc_we_o | output | 1 | Exception PC write |

## Verification
The assertions assume that the opcode and function inputs stay stable from decode until the instruction returns to fetch, because they come from an instruction register that is only loaded in fetch. The stimulus respects this: it changes op and fn only while the phase is fetch. The ALU flags carry no such assumption and are randomized every cycle in the random phase. The overflow-trap property ties phase 9 to an overflow seen one cycle earlier in execute. The illegal-trap property ties phase 10 to a preceding decode.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int PH_W  = 4;
    localparam int SEL_W = 2;

    typedef enum logic [PH_W-1:0] {
        PH_FETCH    = 4'd0,
        PH_DECODE   = 4'd1,
        PH_ADDR     = 4'd2,
        PH_LDRD     = 4'd3,
        PH_LDWB     = 4'd4,
        PH_XFER     = 4'd5,
        PH_STWR     = 4'd6,
        PH_EXEC     = 4'd7,
        PH_ALUWB    = 4'd8,
        PH_TRAP_OVF = 4'd9,
        PH_TRAP_ILL = 4'd10
    } phase_e;

    typedef enum logic [1:0] {IC_ILL, IC_ALU, IC_MEM, IC_XFER} iclass_e;

    typedef enum logic [2:0] {
        XF_NONE, XF_JUMP, XF_LINK, XF_REG, XF_SYS, XF_EQ, XF_NE, XF_NEG
    } xfer_e;

    // opcode values decoded by the sequencer
    localparam logic [OP_W-1:0] OPC_RFORM = 6'd0;
    localparam logic [OP_W-1:0] OPC_BLTZ  = 6'd1;
    localparam logic [OP_W-1:0] OPC_J     = 6'd2;
    localparam logic [OP_W-1:0] OPC_JAL   = 6'd3;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OP_W-1:0] OPC_BNE   = 6'd5;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OP_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OP_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OP_W-1:0] OPC_XORI  = 6'd14;
    localparam logic [OP_W-1:0] OPC_LUI   = 6'd15;
    localparam logic [OP_W-1:0] OPC_LW    = 6'd35;
    localparam logic [OP_W-1:0] OPC_SW    = 6'd43;

    // function values under the register form
    localparam logic [FN_W-1:0] FN_JR  = 6'd8;
    localparam logic [FN_W-1:0] FN_SYS = 6'd12;
    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB = 6'd34;
    localparam logic [FN_W-1:0] FN_AND = 6'd36;
    localparam logic [FN_W-1:0] FN_OR  = 6'd37;
    localparam logic [FN_W-1:0] FN_XOR = 6'd38;
    localparam logic [FN_W-1:0] FN_NOR = 6'd39;
    localparam logic [FN_W-1:0] FN_SLT = 6'd42;

    // select codes towards the datapath
    localparam logic [SEL_W-1:0] PCS_JUMP = 2'd0;
    localparam logic [SEL_W-1:0] PCS_REG  = 2'd1;
    localparam logic [SEL_W-1:0] PCS_BR   = 2'd2;
    localparam logic [SEL_W-1:0] PCS_INC  = 2'd3;

    localparam logic [SEL_W-1:0] YS_FOUR  = 2'd0;
    localparam logic [SEL_W-1:0] YS_REG   = 2'd1;
    localparam logic [SEL_W-1:0] YS_IMM   = 2'd2;
    localparam logic [SEL_W-1:0] YS_OFFS  = 2'd3;

    localparam logic [SEL_W-1:0] DST_RT   = 2'd0;
    localparam logic [SEL_W-1:0] DST_RD   = 2'd1;
    localparam logic [SEL_W-1:0] DST_LINK = 2'd2;

    localparam logic [SEL_W-1:0] FC_UPPER = 2'd0;
    localparam logic [SEL_W-1:0] FC_SLT   = 2'd1;
    localparam logic [SEL_W-1:0] FC_ARITH = 2'd2;
    localparam logic [SEL_W-1:0] FC_LOGIC = 2'd3;

    localparam logic [SEL_W-1:0] LF_AND = 2'd0;
    localparam logic [SEL_W-1:0] LF_OR  = 2'd1;
    localparam logic [SEL_W-1:0] LF_XOR = 2'd2;
    localparam logic [SEL_W-1:0] LF_NOR = 2'd3;

    typedef struct packed {
        iclass_e          cls;
        logic             rform;
        logic             is_load;
        logic             can_ovf;
        logic [SEL_W-1:0] fclass;
        logic [SEL_W-1:0] lfn;
        logic             sub;
        xfer_e            xfer;
    } dec_t;

    typedef struct packed {
        logic             pc_we;
        logic [SEL_W-1:0] pc_src;
        logic             vec_sel;
        logic             mem_dside;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_we;
        logic             rf_we;
        logic [SEL_W-1:0] rf_dst;
        logic             rf_din;
        logic             alu_x;
        logic [SEL_W-1:0] alu_y;
        logic             alu_sub;
        logic [SEL_W-1:0] alu_class;
        logic [SEL_W-1:0] alu_logic;
        logic             cause_we;
        logic             cause;
        logic             epc_we;
    } ctl_t;

    function automatic ctl_t ctl_quiet();
        ctl_t c;
        c = '0;
        return c;
    endfunction

    // ALU set-up shared by the address-computing phases
    function automatic ctl_t ctl_alu(input logic x, input logic [SEL_W-1:0] y,
                                     input logic sub);
        ctl_t c;
        c           = '0;
        c.alu_x     = x;
        c.alu_y     = y;
        c.alu_sub   = sub;
        c.alu_class = FC_ARITH;
        return c;
    endfunction

endpackage

// File: rtl/mcyc_decode.sv
module mcyc_decode
    import mcyc_ctrl_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [FN_W-1:0] fn_i,
    output dec_t            dec_o
);

    dec_t d;

    always_comb begin
        d         = '0;
        d.cls     = IC_ILL;
        d.xfer    = XF_NONE;
        d.fclass  = FC_ARITH;
        d.lfn     = LF_AND;
        case (op_i)
            OPC_RFORM: begin
                d.rform = 1'b1;
                case (fn_i)
                    FN_ADD: begin d.cls = IC_ALU; d.can_ovf = 1'b1; end
                    FN_SUB: begin d.cls = IC_ALU; d.can_ovf = 1'b1; d.sub = 1'b1; end
                    FN_SLT: begin d.cls = IC_ALU; d.fclass = FC_SLT; d.sub = 1'b1; end
                    FN_AND: begin d.cls = IC_ALU; d.fclass = FC_LOGIC; d.lfn = LF_AND; end
                    FN_OR:  begin d.cls = IC_ALU; d.fclass = FC_LOGIC; d.lfn = LF_OR;  end
                    FN_XOR: begin d.cls = IC_ALU; d.fclass = FC_LOGIC; d.lfn = LF_XOR; end
                    FN_NOR: begin d.cls = IC_ALU; d.fclass = FC_LOGIC; d.lfn = LF_NOR; end
                    FN_JR:  begin d.cls = IC_XFER; d.xfer = XF_REG; end
                    FN_SYS: begin d.cls = IC_XFER; d.xfer = XF_SYS; end
                    default: d.cls = IC_ILL;
                endcase
            end
            OPC_LUI:  begin d.cls = IC_ALU; d.fclass = FC_UPPER; end
            OPC_ADDI: begin d.cls = IC_ALU; d.can_ovf = 1'b1; end
            OPC_SLTI: begin d.cls = IC_ALU; d.fclass = FC_SLT; d.sub = 1'b1; end
            OPC_ANDI: begin d.cls = IC_ALU; d.fclass = FC_LOGIC; d.lfn = LF_AND; end
            OPC_ORI:  begin d.cls = IC_ALU; d.fclass = FC_LOGIC; d.lfn = LF_OR;  end
            OPC_XORI: begin d.cls = IC_ALU; d.fclass = FC_LOGIC; d.lfn = LF_XOR; end
            OPC_LW:   begin d.cls = IC_MEM; d.is_load = 1'b1; end
            OPC_SW:   d.cls = IC_MEM;
            OPC_J:    begin d.cls = IC_XFER; d.xfer = XF_JUMP; end
            OPC_JAL:  begin d.cls = IC_XFER; d.xfer = XF_LINK; end
            OPC_BEQ:  begin d.cls = IC_XFER; d.xfer = XF_EQ;   end
            OPC_BNE:  begin d.cls = IC_XFER; d.xfer = XF_NE;   end
            OPC_BLTZ: begin d.cls = IC_XFER; d.xfer = XF_NEG;  end
            default:  d.cls = IC_ILL;
        endcase
    end

    assign dec_o = d;

endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
    import mcyc_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_e cls_i,
    input  logic    is_load_i,
    input  logic    can_ovf_i,
    input  logic    alu_ovf_i,
    output phase_e  phase_o
);

    phase_e ph_q;
    phase_e ph_d;

    always_comb begin
        ph_d = PH_FETCH;
        case (ph_q)
            PH_FETCH:  ph_d = PH_DECODE;
            PH_DECODE: begin
                case (cls_i)
                    IC_ALU:  ph_d = PH_EXEC;
                    IC_MEM:  ph_d = PH_ADDR;
                    IC_XFER: ph_d = PH_XFER;
                    default: ph_d = PH_TRAP_ILL;
                endcase
            end
            PH_ADDR:   ph_d = is_load_i ? PH_LDRD : PH_STWR;
            PH_LDRD:   ph_d = PH_LDWB;
            PH_EXEC:   ph_d = (can_ovf_i && alu_ovf_i) ? PH_TRAP_OVF : PH_ALUWB;
            default:   ph_d = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_FETCH;
        else     ph_q <= ph_d;
    end

    assign phase_o = ph_q;

endmodule

// File: rtl/mcyc_drive.sv
module mcyc_drive
    import mcyc_ctrl_pkg::*;
(
    input  phase_e           phase_i,
    input  logic             rform_i,
    input  logic [SEL_W-1:0] fclass_i,
    input  logic [SEL_W-1:0] lfn_i,
    input  logic             sub_i,
    input  xfer_e            xfer_i,
    input  logic             alu_zero_i,
    input  logic             alu_msb_i,
    output ctl_t             ctl_o
);

    ctl_t c;

    always_comb begin
        c = ctl_quiet();
        case (phase_i)
            PH_FETCH: begin
                c        = ctl_alu(1'b0, YS_FOUR, 1'b0);
                c.mem_rd = 1'b1;
                c.ir_we  = 1'b1;
                c.pc_we  = 1'b1;
                c.pc_src = PCS_INC;
            end
            PH_DECODE: c = ctl_alu(1'b0, YS_OFFS, 1'b0);
            PH_ADDR:   c = ctl_alu(1'b1, YS_IMM, 1'b0);
            PH_LDRD: begin
                c.mem_dside = 1'b1;
                c.mem_rd    = 1'b1;
            end
            PH_LDWB: begin
                c.rf_we  = 1'b1;
                c.rf_dst = DST_RT;
                c.rf_din = 1'b0;
            end
            PH_STWR: begin
                c.mem_dside = 1'b1;
                c.mem_wr    = 1'b1;
            end
            PH_EXEC: begin
                c.alu_x     = 1'b1;
                c.alu_y     = rform_i ? YS_REG : YS_IMM;
                c.alu_sub   = sub_i;
                c.alu_class = fclass_i;
                c.alu_logic = lfn_i;
            end
            PH_ALUWB: begin
                c.rf_we  = 1'b1;
                c.rf_din = 1'b1;
                c.rf_dst = rform_i ? DST_RD : DST_RT;
            end
            PH_XFER: begin
                c = ctl_alu(1'b1, YS_REG, 1'b1);
                case (xfer_i)
                    XF_JUMP: begin c.pc_src = PCS_JUMP; c.pc_we = 1'b1; end
                    XF_LINK: begin
                        c.pc_src = PCS_JUMP;
                        c.pc_we  = 1'b1;
                        c.rf_we  = 1'b1;
                        c.rf_dst = DST_LINK;
                        c.rf_din = 1'b1;
                    end
                    XF_SYS: begin c.vec_sel = 1'b1; c.pc_src = PCS_JUMP; c.pc_we = 1'b1; end
                    XF_REG: begin c.pc_src = PCS_REG; c.pc_we = 1'b1; end
                    XF_EQ:  begin c.pc_src = PCS_BR; c.pc_we = alu_zero_i;  end
                    XF_NE:  begin c.pc_src = PCS_BR; c.pc_we = ~alu_zero_i; end
                    XF_NEG: begin c.pc_src = PCS_BR; c.pc_we = alu_msb_i;   end
                    default: c.pc_we = 1'b0;
                endcase
            end
            PH_TRAP_OVF, PH_TRAP_ILL: begin
                c          = ctl_alu(1'b0, YS_FOUR, 1'b1);
                c.cause_we = 1'b1;
                c.cause    = (phase_i == PH_TRAP_OVF);
                c.epc_we   = 1'b1;
                c.vec_sel  = 1'b1;
                c.pc_src   = PCS_JUMP;
                c.pc_we    = 1'b1;
            end
            default: c = ctl_quiet();
        endcase
    end

    assign ctl_o = c;

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  op_i,
    input  logic [FN_W-1:0]  fn_i,
    input  logic             alu_zero_i,
    input  logic             alu_ovf_i,
    input  logic             alu_msb_i,
    output logic [PH_W-1:0]  phase_o,
    output logic             pc_we_o,
    output logic [SEL_W-1:0] pc_src_o,
    output logic             vec_sel_o,
    output logic             mem_dside_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             ir_we_o,
    output logic             rf_we_o,
    output logic [SEL_W-1:0] rf_dst_o,
    output logic             rf_din_o,
    output logic             alu_x_o,
    output logic [SEL_W-1:0] alu_y_o,
    output logic             alu_sub_o,
    output logic [SEL_W-1:0] alu_class_o,
    output logic [SEL_W-1:0] alu_logic_o,
    output logic             cause_we_o,
    output logic             cause_o,
    output logic             epc_we_o
);

    dec_t   dec;
    phase_e phase;
    ctl_t   ctl;

    mcyc_decode u_decode (
        .op_i  (op_i),
        .fn_i  (fn_i),
        .dec_o (dec)
    );

    mcyc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cls_i     (dec.cls),
        .is_load_i (dec.is_load),
        .can_ovf_i (dec.can_ovf),
        .alu_ovf_i (alu_ovf_i),
        .phase_o   (phase)
    );

    mcyc_drive u_drive (
        .phase_i    (phase),
        .rform_i    (dec.rform),
        .fclass_i   (dec.fclass),
        .lfn_i      (dec.lfn),
        .sub_i      (dec.sub),
        .xfer_i     (dec.xfer),
        .alu_zero_i (alu_zero_i),
        .alu_msb_i  (alu_msb_i),
        .ctl_o      (ctl)
    );

    assign phase_o     = phase;
    assign pc_we_o     = ctl.pc_we;
    assign pc_src_o    = ctl.pc_src;
    assign vec_sel_o   = ctl.vec_sel;
    assign mem_dside_o = ctl.mem_dside;
    assign mem_rd_o    = ctl.mem_rd;
    assign mem_wr_o    = ctl.mem_wr;
    assign ir_we_o     = ctl.ir_we;
    assign rf_we_o     = ctl.rf_we;
    assign rf_dst_o    = ctl.rf_dst;
    assign rf_din_o    = ctl.rf_din;
    assign alu_x_o     = ctl.alu_x;
    assign alu_y_o     = ctl.alu_y;
    assign alu_sub_o   = ctl.alu_sub;
    assign alu_class_o = ctl.alu_class;
    assign alu_logic_o = ctl.alu_logic;
    assign cause_we_o  = ctl.cause_we;
    assign cause_o     = ctl.cause;
    assign epc_we_o    = ctl.epc_we;

endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] phase,
    input logic       alu_ovf,
    input logic       pc_we,
    input logic [1:0] pc_src,
    input logic       vec_sel,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       rf_we,
    input logic       cause_we,
    input logic       epc_we
);

    p_fetch_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> phase == 4'd0);

    p_decode_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        phase == 4'd1 |-> !pc_we && !rf_we && !mem_rd && !mem_wr);

    p_wb_returns_r3: assert property (@(posedge clk) disable iff (rst)
        phase == 4'd8 |=> phase == 4'd0);

    p_load_order_r5: assert property (@(posedge clk) disable iff (rst)
        phase == 4'd3 |=> phase == 4'd4);

    p_ovf_entry_r10: assert property (@(posedge clk) disable iff (rst)
        phase == 4'd9 |-> $past(phase) == 4'd7 && $past(alu_ovf));

    p_trap_vector_r11: assert property (@(posedge clk) disable iff (rst)
        (phase == 4'd9 || phase == 4'd10) |->
            pc_we && pc_src == 2'd0 && vec_sel && cause_we && epc_we);

    p_ill_entry_r12: assert property (@(posedge clk) disable iff (rst)
        phase == 4'd10 |-> $past(phase) == 4'd1);

    p_mem_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase_o),
    .alu_ovf  (alu_ovf_i),
    .pc_we    (pc_we_o),
    .pc_src   (pc_src_o),
    .vec_sel  (vec_sel_o),
    .mem_rd   (mem_rd_o),
    .mem_wr   (mem_wr_o),
    .rf_we    (rf_we_o),
    .cause_we (cause_we_o),
    .epc_we   (epc_we_o)
);

// File: tb/test_mcyc_ctrl.sv
module test_mcyc_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int N_RANDOM   = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] op = '0;
    logic [5:0] fn = '0;
    logic       zf = 1'b0, of = 1'b0, mf = 1'b0;

    logic [3:0] phase_o;
    logic       pc_we_o, vec_sel_o, mem_dside_o, mem_rd_o, mem_wr_o, ir_we_o;
    logic       rf_we_o, rf_din_o, alu_x_o, alu_sub_o, cause_we_o, cause_o, epc_we_o;
    logic [1:0] pc_src_o, rf_dst_o, alu_y_o, alu_class_o, alu_logic_o;

    int total = 0;
    int bad   = 0;
    int m_state = 0;
    bit started = 1'b0;
    bit rnd_flags = 1'b0;

    // entry layout: {rnd, op[5:0], fn[5:0], zero, ovf, msb}
    logic [15:0] stim_q[$];

    mcyc_ctrl i_mcyc_ctrl (
        .clk(clk), .rst(rst), .op_i(op), .fn_i(fn),
        .alu_zero_i(zf), .alu_ovf_i(of), .alu_msb_i(mf),
        .phase_o(phase_o), .pc_we_o(pc_we_o), .pc_src_o(pc_src_o),
        .vec_sel_o(vec_sel_o), .mem_dside_o(mem_dside_o), .mem_rd_o(mem_rd_o),
        .mem_wr_o(mem_wr_o), .ir_we_o(ir_we_o), .rf_we_o(rf_we_o),
        .rf_dst_o(rf_dst_o), .rf_din_o(rf_din_o), .alu_x_o(alu_x_o),
        .alu_y_o(alu_y_o), .alu_sub_o(alu_sub_o), .alu_class_o(alu_class_o),
        .alu_logic_o(alu_logic_o), .cause_we_o(cause_we_o), .cause_o(cause_o),
        .epc_we_o(epc_we_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // instruction kind: 0 illegal, 1 ALU, 2 load, 3 store, 4 transfer
    function automatic int kind_of(input logic [5:0] o, input logic [5:0] f);
        if (o == 0) begin
            if (f == 32 || f == 34 || f == 42 || (f >= 36 && f <= 39)) return 1;
            if (f == 8 || f == 12) return 4;
            return 0;
        end
        if (o == 8 || o == 10 || (o >= 12 && o <= 15)) return 1;
        if (o == 35) return 2;
        if (o == 43) return 3;
        if (o >= 1 && o <= 5) return 4;
        return 0;
    endfunction

    function automatic bit traps(input logic [5:0] o, input logic [5:0] f);
        return (o == 8) || (o == 0 && (f == 32 || f == 34));
    endfunction

    function automatic int next_of(input int s, input logic [5:0] o, input logic [5:0] f,
                                   input logic ov);
        int k;
        k = kind_of(o, f);
        if (s == 0) return 1;
        if (s == 1) return (k == 1) ? 7 : (k == 2 || k == 3) ? 2 : (k == 4) ? 5 : 10;
        if (s == 2) return (k == 2) ? 3 : 6;
        if (s == 3) return 4;
        if (s == 7) return (ov && traps(o, f)) ? 9 : 8;
        return 0;
    endfunction

    function automatic logic [26:0] exp_vec(input int s, input logic [5:0] o,
                                            input logic [5:0] f, input logic z,
                                            input logic m);
        logic       pw = 0, vs = 0, ds = 0, rd = 0, wr = 0, ir = 0, rw = 0, din = 0;
        logic       ax = 0, sb = 0, cw = 0, cv = 0, ew = 0;
        logic [1:0] ps = 0, dst = 0, ay = 0, cl = 0, lg = 0;
        case (s)
            0: begin pw = 1; ps = 3; rd = 1; ir = 1; cl = 2; end
            1: begin ay = 3; cl = 2; end
            2: begin ax = 1; ay = 2; cl = 2; end
            3: begin ds = 1; rd = 1; end
            4: begin rw = 1; end
            6: begin ds = 1; wr = 1; end
            5: begin
                ax = 1; ay = 1; sb = 1; cl = 2;
                if (o == 2) pw = 1;
                else if (o == 3) begin pw = 1; rw = 1; dst = 2; din = 1; end
                else if (o == 0 && f == 12) begin pw = 1; vs = 1; end
                else if (o == 0 && f == 8) begin pw = 1; ps = 1; end
                else if (o == 4) begin ps = 2; pw = z; end
                else if (o == 5) begin ps = 2; pw = !z; end
                else if (o == 1) begin ps = 2; pw = m; end
            end
            7: begin
                ax = 1;
                ay = (o == 0) ? 2'd1 : 2'd2;
                if (o == 15) cl = 0;
                else if ((o == 0 && f == 42) || o == 10) begin cl = 1; sb = 1; end
                else if (o == 0 && f == 34) begin cl = 2; sb = 1; end
                else if ((o == 0 && f == 32) || o == 8) cl = 2;
                else begin
                    cl = 3;
                    if ((o == 0 && f == 37) || o == 13) lg = 1;
                    else if ((o == 0 && f == 38) || o == 14) lg = 2;
                    else if (o == 0 && f == 39) lg = 3;
                end
            end
            8: begin rw = 1; din = 1; dst = (o == 0) ? 2'd1 : 2'd0; end
            9, 10: begin
                cw = 1; cv = (s == 9); ew = 1; sb = 1; cl = 2;
                vs = 1; ps = 0; pw = 1;
            end
            default: ;
        endcase
        return {4'(s), pw, ps, vs, ds, rd, wr, ir, rw, dst, din, ax, ay, sb, cl, lg,
                cw, cv, ew};
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R5";
            5: return "R7,R8,R9";
            6: return "R6";
            7: return "R4";
            8: return "R3";
            9: return "R10,R11";
            default: return "R11,R12";
        endcase
    endfunction

    // behavioural reference: phase sequence
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) m_state <= 0;
        else     m_state <= next_of(m_state, op, fn, of);
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (started) begin
            logic [26:0] got, exp;
            got = {phase_o, pc_we_o, pc_src_o, vec_sel_o, mem_dside_o, mem_rd_o,
                   mem_wr_o, ir_we_o, rf_we_o, rf_dst_o, rf_din_o, alu_x_o, alu_y_o,
                   alu_sub_o, alu_class_o, alu_logic_o, cause_we_o, cause_o, epc_we_o};
            exp = exp_vec(m_state, op, fn, zf, mf);
            total++;
            if (got !== exp) begin
                bad++;
                $display("FAIL %s phase=%0d op=%0d fn=%0d actual=%h expected=%h",
                         tag_of(m_state), m_state, op, fn, got, exp);
            end
            total++;
            if (mem_rd_o && mem_wr_o) begin
                bad++;
                $display("FAIL R13 read and write together actual=11 expected=not both");
            end
        end
    end

    task automatic push(input bit r, input int o, input int f, input bit z,
                        input bit v, input bit m);
        stim_q.push_back({r, 6'(o), 6'(f), z, v, m});
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stimulus
        int legal_op[22] = '{0,0,0,0,0,0,0,15,8,10,12,13,14,35,43,2,0,1,4,5,3,0};
        int legal_fn[22] = '{32,34,42,36,37,38,39,0,0,0,0,0,0,0,0,0,8,0,0,0,0,12};
        // R1 R3 R4: every ALU instruction, no overflow
        for (int i = 0; i < 13; i++) push(0, legal_op[i], legal_fn[i], 0, 0, 0);
        // R5 R6: load and store
        push(0, 35, 0, 0, 0, 0);
        push(0, 43, 0, 0, 1, 0);
        // R7 R8 R9: transfers with both flag values
        push(0, 2, 0, 0, 0, 0);
        push(0, 3, 0, 0, 0, 0);
        push(0, 0, 8, 0, 0, 0);
        push(0, 0, 12, 0, 0, 0);
        push(0, 4, 0, 1, 0, 0);
        push(0, 4, 0, 0, 0, 0);
        push(0, 5, 0, 1, 0, 0);
        push(0, 5, 0, 0, 0, 0);
        push(0, 1, 0, 0, 0, 1);
        push(0, 1, 0, 0, 0, 0);
        // R10 R11: trapping overflow on add, sub, addi
        push(0, 0, 32, 0, 1, 0);
        push(0, 0, 34, 0, 1, 0);
        push(0, 8, 0, 0, 1, 0);
        // R10: overflow flag ignored for slt, and, lui, slti, ori
        push(0, 0, 42, 0, 1, 0);
        push(0, 0, 36, 0, 1, 0);
        push(0, 15, 0, 0, 1, 0);
        push(0, 10, 0, 0, 1, 0);
        push(0, 13, 0, 0, 1, 0);
        // R12: illegal encodings
        push(0, 63, 0, 0, 0, 0);
        push(0, 0, 0, 0, 0, 0);
        push(0, 0, 13, 0, 0, 0);
        push(0, 9, 0, 0, 0, 0);
        push(0, 0, 40, 0, 1, 0);
        // random mix, flags change every cycle
        for (int i = 0; i < N_RANDOM; i++) begin
            int pick;
            pick = $urandom_range(0, 25);
            if (pick < 22) push(1, legal_op[pick], legal_fn[pick], 0, 0, 0);
            else push(1, $urandom_range(0, 63), $urandom_range(0, 63), 0, 0, 0);
        end

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        forever begin
            if (m_state == 0) begin
                logic [15:0] e;
                if (stim_q.size() == 0) break;
                e = stim_q.pop_front();
                rnd_flags = e[15];
                op = e[14:9];
                fn = e[8:3];
                {zf, of, mf} = e[2:0];
            end
            if (rnd_flags) begin
                zf = 1'($urandom);
                of = 1'($urandom);
                mf = 1'($urandom);
            end
            @(posedge clk);
            #1;
        end
        @(negedge clk);
        #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule